// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt lines from on-chip communication peripherals and folds them into one request toward a host processor. Each line latches into a pending bit. A per-line enable mask and a global enable decide whether the request is raised. Software finds out which line to serve through a two-step sequence: it writes an acknowledge bit in the vector register, then reads that register back. The vector number of the line that won arbitration sits in bits 15:11.

Arbitration has three tiers, checked in order:
- A configurable single line can be promoted above all others.
- Four serial-channel lines form a group. Their relative order comes from four two-bit slot fields.
- All remaining lines follow a fixed order, and the higher number wins.

Vector 0 is reserved as the error vector. It is returned when the acknowledge finds nothing left to serve, for example after the line was masked or cleared since the request rose. Software clears a served line by writing a one to its pending bit.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset the configuration, pending, mask and vector registers all read 0, and `irq_req` is low.
- R2: A high level on `src[i]` at a clock edge sets pending bit i. The bit stays set after the line drops. Line 0 is reserved and its pending bit never sets.
- R3: A write to the pending register (addr 1) clears every pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R4: Mask bit i (addr 2) enables line i. `irq_req` is high exactly when the global enable is set and some pending bit has its mask bit set.
- R5: The global enable, configuration bit 7, holds `irq_req` low while it is 0, whatever is pending.
- R6: A write to addr 3 with data bit 0 set latches the winning vector. Reading addr 3 returns it in bits 15:11, with all other bits 0. A write to addr 3 with bit 0 clear leaves the vector unchanged.
- R7: Among pending, unmasked lines that are neither promoted nor serial channels, the highest line number wins.
- R8: Configuration bits 12:8 name a promoted line. If that line is pending and unmasked, it wins over every other line. The value 0 promotes nothing.
- R9: Lines CH_BASE..CH_BASE+3 (28..31 by default) are serial channels 0..3. They rank above the fixed order and below the promoted line. Slot fields in configuration bits 17:16, 19:18, 21:20 and 23:22 each name a channel, and the slots are ranked from highest to lowest in that order.
- R10: An acknowledge while no line is both pending and unmasked latches vector 0.
- R11: Configuration bits 15:13 drive `irq_level`. The configuration register keeps only bits 23:7 and reads all other bits as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 32 | Level-sensitive interrupt lines, bit i is line i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 config, 1 pending, 2 mask, 3 vector |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_level | output | 3 | Request level for the processor |

## Verification
The bench targets the race that the error vector exists for. It masks a line that already raised the request and then acknowledges. A design that kept the old winner, or latched the stale request, would return a real vector instead of 0. It walks the channel group through a deliberately scrambled slot assignment, clearing one line at a time. A design that ranked channels by their line numbers would serve them in the wrong sequence. It also checks the promoted line against higher-numbered competitors, and checks that write-zero bits and acknowledge writes with bit 0 clear change nothing. Either mistake would show up as a lost pending bit or an overwritten vector.

// File: rtl/vpic_ctrl.sv
module vpic_ctrl #(
  parameter int CH_BASE = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_req,
  output logic [2:0]  irq_level
);
  localparam int VW   = 5;
  localparam int NSRC = 1 << VW;
  localparam logic [31:0] CFG_KEEP = 32'h00FF_FF80;

  logic [31:0]     cfg_q;
  logic [NSRC-1:0] pend_q, mask_q, active, clr_vec;
  logic [VW-1:0]   vec_q, fix_win, ch_win, win;
  logic            ch_any, hp_hit, ack;
  logic [VW-1:0]   hp_sel;

  assign hp_sel    = cfg_q[12:8];
  assign irq_level = cfg_q[15:13];
  assign active    = pend_q & mask_q;
  assign irq_req   = cfg_q[7] & (|active);
  assign ack       = wr_en && addr == 2'd3 && wdata[0];
  assign clr_vec   = (wr_en && addr == 2'd1) ? wdata : '0;
  assign hp_hit    = (hp_sel != '0) && active[hp_sel];

  always_comb begin
    fix_win = '0;
    for (int i = 1; i < NSRC; i++)
      if (active[i]) fix_win = VW'(i);
  end

  always_comb begin
    logic [VW-1:0] cand;
    ch_win = '0;
    ch_any = 1'b0;
    for (int s = 3; s >= 0; s--) begin
      cand = VW'(CH_BASE) + VW'(cfg_q[16 + 2*s +: 2]);
      if (active[cand]) begin
        ch_win = cand;
        ch_any = 1'b1;
      end
    end
  end

  assign win = hp_hit ? hp_sel : (ch_any ? ch_win : fix_win);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pend_q <= '0;
      mask_q <= '0;
      vec_q  <= '0;
    end else begin
      pend_q <= ((pend_q & ~clr_vec) | src) & ~NSRC'(1);
      if (wr_en && addr == 2'd0) cfg_q  <= wdata & CFG_KEEP;
      if (wr_en && addr == 2'd2) mask_q <= wdata;
      if (ack) vec_q <= (|active) ? win : '0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cfg_q;
      2'd1:    rdata = pend_q;
      2'd2:    rdata = mask_q;
      default: rdata = {16'd0, vec_q, 11'd0};
    endcase
  end

  AST_IDLE_ACK_ERRVEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && active == '0) |=> vec_q == '0); // R10
  AST_VEC_WAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (vec_q == '0) || ((($past(active) >> vec_q) & 32'd1) != 32'd0)); // R6
  AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(vec_q)); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> (pend_q & $past(clr_vec & ~src)) == '0); // R3
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(clr_vec)) & ~pend_q) == '0); // R2
  AST_PROMOTED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hp_hit) |=> vec_q == $past(hp_sel)); // R8
endmodule

// File: tb/vpic_ctrl_tb.sv
module vpic_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src = '0;
  logic        wr_en = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req;
  logic [2:0]  irq_level;

  always #4 clk = ~clk;

  vpic_ctrl dut_i (.clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .irq_level(irq_level));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int errors = 0, checks = 0;
  logic probe = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (probe && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'd0, irq_req} : {29'd0, irq_level};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic expect_q(input int kind, input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); #1;
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
    probe = 1;
    @(negedge clk); #1;
    probe = 0;
  endtask

  task automatic pulse_src(input logic [31:0] v);
    @(negedge clk); #1; src = v;
    @(negedge clk); #1; src = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    expect_q(0, 0, 0, "R1 cfg");
    expect_q(0, 1, 0, "R1 pend");
    expect_q(0, 2, 0, "R1 mask");
    expect_q(0, 3, 0, "R1 vec");
    expect_q(1, 0, 0, "R1 irq");

    pulse_src(32'h0000_0029);
    expect_q(0, 1, 32'h28, "R2 pending latched, line 0 ignored");
    expect_q(1, 0, 0, "R4 no mask no irq");
    wr(2, 32'h20);
    expect_q(0, 2, 32'h20, "R4 mask readback");
    expect_q(1, 0, 0, "R5 enable off gates irq");
    wr(0, 32'h80);
    expect_q(1, 0, 1, "R4 irq raised");
    wr(2, 32'h28);
    wr(3, 1);
    expect_q(0, 3, 32'h2800, "R7 highest number wins");
    wr(1, 32'h20);
    expect_q(0, 1, 32'h08, "R3 w1c clears bit5");
    wr(1, 32'h0);
    expect_q(0, 1, 32'h08, "R3 write zero no effect");
    expect_q(1, 0, 1, "R4 irq still up");
    wr(3, 1);
    expect_q(0, 3, 32'h1800, "R7 remaining line 3");

    pulse_src(32'h0000_0200);
    wr(0, 32'h80 | (32'd3 << 8));
    wr(2, 32'h228);
    wr(3, 1);
    expect_q(0, 3, 32'h1800, "R8 promoted line 3 beats 9");
    wr(0, 32'h80);
    wr(3, 1);
    expect_q(0, 3, 32'h4800, "R7 line 9 without promotion");
    wr(3, 0);
    expect_q(0, 3, 32'h4800, "R6 ack bit clear no effect");
    wr(2, 0);
    expect_q(1, 0, 0, "R4 masked drops irq");
    wr(3, 1);
    expect_q(0, 3, 0, "R10 error vector after masking");

    wr(1, 32'hFFFF_FFFF);
    expect_q(0, 1, 0, "R3 clear all");
    pulse_src(32'hF000_0400);
    wr(0, 32'h8D_0080);
    wr(2, 32'hFFFF_FFFF);
    wr(3, 1);
    expect_q(0, 3, 32'd29 << 11, "R9 slot A channel 1");
    wr(1, 32'h2000_0000);
    wr(3, 1);
    expect_q(0, 3, 32'd31 << 11, "R9 slot B channel 3");
    wr(1, 32'h8000_0000);
    wr(3, 1);
    expect_q(0, 3, 32'd28 << 11, "R9 slot C channel 0");
    wr(1, 32'h1000_0000);
    wr(3, 1);
    expect_q(0, 3, 32'd30 << 11, "R9 slot D channel 2");
    wr(1, 32'h4000_0000);
    wr(3, 1);
    expect_q(0, 3, 32'd10 << 11, "R9 fixed order after channels");

    wr(0, 32'hFFFF_FFFF);
    expect_q(0, 0, 32'h00FF_FF80, "R11 cfg keeps bits 23:7");
    wr(0, 32'h0000_A080);
    expect_q(2, 0, 5, "R11 level output");
    wr(0, 32'h0);
    expect_q(1, 0, 0, "R5 enable cleared drops irq");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule